// File: doc/BRIEF.md
# Input Adapter Switch Protection Sequencer

This block decides when the external switch between the adapter input and the system may conduct. It takes six comparator results that are already digital. These are adapter present, input supply above battery, input overvoltage, input overcurrent, die over-temperature and system overvoltage. Each result passes through its own filter, with one settle time for the rising edge and another for the falling edge. Time is counted in pulses of a one-per-microsecond tick input, so all settle times are parameters in microseconds.

The switch enable is high only when all of these hold at once:
- adapter present (filtered),
- supply above battery (filtered),
- no filtered input overvoltage,
- no overcurrent relax period running,
- no filtered over-temperature,
- no system-overvoltage latch.

After an overcurrent event the switch stays off for a long relax period and then retries by itself. A system overvoltage that persists latches the switch off. The latch clears only when the raw adapter-present flag falls, or on reset. A separate adapter-OK status output carries only the filtered adapter-present flag.

Top module: `adapter_switch_seq`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low on a clock edge, every filter, the relax timer and the latch clear. `sw_en` and `adapter_ok` are low afterwards.
- R2: `adapter_ok` rises after `adp_det_raw` has been high for ADP_RISE_US consecutive ticks. It falls after `adp_det_raw` has been low for ADP_FALL_US consecutive ticks.
- R3: In every filter, a raw input that returns to the filtered value before its settle count completes restarts that count from zero.
- R4: The supply-above-battery flag needs VAB_RISE_US consecutive high ticks to count as present. It needs VAB_FALL_US consecutive low ticks to count as lost.
- R5: `sw_en` is the AND of six terms: filtered adapter present, filtered supply-above-battery, no filtered overvoltage, no relax period, no filtered over-temperature, and no latch.
- R6: Input overvoltage turns the switch off after OVP_RISE_US ticks of assertion. The switch is allowed back on only after the overvoltage has been absent for OVP_FALL_US ticks.
- R7: A filtered overcurrent starts a relax period. The period lasts for as long as the filtered overcurrent holds and then for RELAX_US further ticks. After that the switch re-enables with no latch-off.
- R8: Over-temperature takes effect after TS_RISE_US ticks high and clears after TS_FALL_US ticks low.
- R9: A system overvoltage high for SOVP_RISE_US ticks sets a latch. The latch keeps the switch off after the overvoltage is removed.
- R10: The latch clears on the clock edge that sees `adp_det_raw` fall from one cycle to the next. After that the switch can enable again once the adapter is re-qualified.
- R11: `adapter_ok` does not depend on any fault path. It stays high during an overvoltage or other fault that forces `sw_en` low.
- R12: Filters and the relax timer advance only in cycles where `tick_us` is high. With no ticks, no filtered state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| adp_det_raw | input | 1 | Adapter present comparator |
| vab_raw | input | 1 | Input supply above battery comparator |
| in_ovp_raw | input | 1 | Input overvoltage comparator |
| in_ocp_raw | input | 1 | Input overcurrent comparator |
| tshut_raw | input | 1 | Die over-temperature comparator |
| sys_ovp_raw | input | 1 | System overvoltage comparator |
| sw_en | output | 1 | Input switch enable |
| adapter_ok | output | 1 | Filtered adapter present status |

## Verification
The hardest state to reach from the ports is a latched system overvoltage on a fully qualified adapter. Getting there needs both the adapter and supply filters to have completed first. The fault must also outlast its own filter. The only exit is a raw adapter fall followed by a fresh rise qualification. The bench therefore applies the faults one after another on an already enabled switch. It ends with the latch sequence and observes the switch staying off after the fault is removed, then re-enabling after the adapter is cycled. A behavioural model tracks run lengths in integers and is compared on every clock. A stretch with the tick held low shows that nothing advances without it.

// File: rtl/adapter_switch_seq_pkg.sv
package adapter_switch_seq_pkg;
   // index of each protected flag inside the filter bank
   typedef enum int unsigned {
      FLG_ADP  = 0,
      FLG_VAB  = 1,
      FLG_OVP  = 2,
      FLG_OCP  = 3,
      FLG_TS   = 4,
      FLG_SOVP = 5
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 6;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/asym_deglitch.sv
module asym_deglitch #(
   parameter int unsigned RISE_TICKS = 4,
   parameter int unsigned FALL_TICKS = 4,
   parameter bit          INIT_VAL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic raw,
   output logic flt
);
   import adapter_switch_seq_pkg::*;

   localparam int unsigned MAXT = max_u(RISE_TICKS, FALL_TICKS);
   localparam int unsigned CW   = (MAXT < 2) ? 1 : $clog2(MAXT + 1);
   localparam logic [CW:0] RISE_W = (CW+1)'(RISE_TICKS);
   localparam logic [CW:0] FALL_W = (CW+1)'(FALL_TICKS);

   if (RISE_TICKS < 1) begin : g_bad_rise
      $error("asym_deglitch: RISE_TICKS must be at least 1");
   end
   if (FALL_TICKS < 1) begin : g_bad_fall
      $error("asym_deglitch: FALL_TICKS must be at least 1");
   end

   logic          flt_q;
   logic [CW-1:0] cnt_q;
   logic [CW:0]   cnt_inc;
   logic [CW:0]   limit;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign limit   = flt_q ? FALL_W : RISE_W;

   if (MAXT == 1) begin : g_direct
      // single-tick settle: the raw value is taken on any tick
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flt_q <= INIT_VAL;
         end else if (tick_us) begin
            flt_q <= raw;
         end
      end
      always_ff @(posedge clk) cnt_q <= '0;
   end else begin : g_counted
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flt_q <= INIT_VAL;
            cnt_q <= '0;
         end else if (raw == flt_q) begin
            cnt_q <= '0;
         end else if (tick_us) begin
            if (cnt_inc >= limit) begin
               flt_q <= raw;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_inc[CW-1:0];
            end
         end
      end
   end

   assign flt = flt_q;

   p_flip_on_tick_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q != $past(flt_q)) |-> $past(tick_us));

   p_flip_follows_raw_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q != $past(flt_q)) |-> (flt_q == $past(raw)));
endmodule

// File: rtl/relax_timer.sv
module relax_timer #(
   parameter int unsigned RELAX_TICKS = 300000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic ocp_flt,
   output logic in_relax
);
   localparam int unsigned CW = (RELAX_TICKS < 2) ? 1 : $clog2(RELAX_TICKS + 1);
   localparam logic [CW-1:0] RELAX_W = CW'(RELAX_TICKS);

   if (RELAX_TICKS < 1) begin : g_bad_relax
      $error("relax_timer: RELAX_TICKS must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ocp_flt) begin
         cnt_q <= RELAX_W;
      end else if (tick_us && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign in_relax = ocp_flt | (cnt_q != '0);

   p_relax_after_ocp_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ocp_flt |=> in_relax);
endmodule

// File: rtl/sysovp_latch.sv
module sysovp_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic adp_det_raw,
   input  logic sovp_flt,
   output logic latched
);
   logic adp_prev_q;
   logic lat_q;
   logic adp_fall;

   assign adp_fall = adp_prev_q & ~adp_det_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adp_prev_q <= 1'b0;
         lat_q      <= 1'b0;
      end else begin
         adp_prev_q <= adp_det_raw;
         if (adp_fall) begin
            lat_q <= 1'b0;
         end else if (sovp_flt) begin
            lat_q <= 1'b1;
         end
      end
   end

   assign latched = lat_q;

   p_latch_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lat_q) && !$past(adp_fall)) |-> lat_q);

   p_latch_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      adp_fall |=> !lat_q);
endmodule

// File: rtl/adapter_switch_seq.sv
module adapter_switch_seq #(
   parameter int unsigned ADP_RISE_US  = 2000,
   parameter int unsigned ADP_FALL_US  = 2,
   parameter int unsigned VAB_RISE_US  = 4000,
   parameter int unsigned VAB_FALL_US  = 100,
   parameter int unsigned OVP_RISE_US  = 100,
   parameter int unsigned OVP_FALL_US  = 3000,
   parameter int unsigned OCP_RISE_US  = 1,
   parameter int unsigned OCP_FALL_US  = 1,
   parameter int unsigned RELAX_US     = 300000,
   parameter int unsigned TS_RISE_US   = 100,
   parameter int unsigned TS_FALL_US   = 10000,
   parameter int unsigned SOVP_RISE_US = 25,
   parameter int unsigned SOVP_FALL_US = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic adp_det_raw,
   input  logic vab_raw,
   input  logic in_ovp_raw,
   input  logic in_ocp_raw,
   input  logic tshut_raw,
   input  logic sys_ovp_raw,
   output logic sw_en,
   output logic adapter_ok
);
   import adapter_switch_seq_pkg::*;

   localparam int unsigned RISE_T [NUM_FLAGS] = '{ADP_RISE_US, VAB_RISE_US, OVP_RISE_US,
                                                  OCP_RISE_US, TS_RISE_US, SOVP_RISE_US};
   localparam int unsigned FALL_T [NUM_FLAGS] = '{ADP_FALL_US, VAB_FALL_US, OVP_FALL_US,
                                                  OCP_FALL_US, TS_FALL_US, SOVP_FALL_US};

   logic [NUM_FLAGS-1:0] raw_v;
   logic [NUM_FLAGS-1:0] flt_v;
   logic                 in_relax;
   logic                 latched;

   assign raw_v[FLG_ADP]  = adp_det_raw;
   assign raw_v[FLG_VAB]  = vab_raw;
   assign raw_v[FLG_OVP]  = in_ovp_raw;
   assign raw_v[FLG_OCP]  = in_ocp_raw;
   assign raw_v[FLG_TS]   = tshut_raw;
   assign raw_v[FLG_SOVP] = sys_ovp_raw;

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_filt
      asym_deglitch #(
         .RISE_TICKS (RISE_T[gi]),
         .FALL_TICKS (FALL_T[gi]),
         .INIT_VAL   (1'b0)
      ) u_dg (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_us (tick_us),
         .raw     (raw_v[gi]),
         .flt     (flt_v[gi])
      );
   end

   relax_timer #(.RELAX_TICKS(RELAX_US)) u_relax (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_us  (tick_us),
      .ocp_flt  (flt_v[FLG_OCP]),
      .in_relax (in_relax)
   );

   sysovp_latch u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .adp_det_raw (adp_det_raw),
      .sovp_flt    (flt_v[FLG_SOVP]),
      .latched     (latched)
   );

   assign adapter_ok = flt_v[FLG_ADP];
   assign sw_en      = flt_v[FLG_ADP] & flt_v[FLG_VAB] & ~flt_v[FLG_OVP]
                     & ~in_relax & ~flt_v[FLG_TS] & ~latched;
endmodule

// File: tb/tb_adapter_switch_seq.sv
module tb_adapter_switch_seq;
   localparam int ADP_R = 20, ADP_F = 2, VAB_R = 40, VAB_F = 10;
   localparam int OVP_R = 10, OVP_F = 30, OCP_R = 3, OCP_F = 1, RELAX = 300;
   localparam int TS_R = 10, TS_F = 100, SOVP_R = 25, SOVP_F = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic tick_en = 1'b1;
   logic phase = 1'b0;
   logic [5:0] raw = '0;  // 0 adp, 1 vab, 2 ovp, 3 ocp, 4 ts, 5 sovp
   logic sw_en, adapter_ok;

   int checks = 0, errors = 0;

   always #2 clk = ~clk;  // 250 MHz

   adapter_switch_seq #(
      .ADP_RISE_US(ADP_R), .ADP_FALL_US(ADP_F), .VAB_RISE_US(VAB_R), .VAB_FALL_US(VAB_F),
      .OVP_RISE_US(OVP_R), .OVP_FALL_US(OVP_F), .OCP_RISE_US(OCP_R), .OCP_FALL_US(OCP_F),
      .RELAX_US(RELAX), .TS_RISE_US(TS_R), .TS_FALL_US(TS_F),
      .SOVP_RISE_US(SOVP_R), .SOVP_FALL_US(SOVP_F)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick),
      .adp_det_raw(raw[0]), .vab_raw(raw[1]), .in_ovp_raw(raw[2]),
      .in_ocp_raw(raw[3]), .tshut_raw(raw[4]), .sys_ovp_raw(raw[5]),
      .sw_en(sw_en), .adapter_ok(adapter_ok)
   );

   // tick generator: one pulse every second cycle while enabled
   always @(negedge clk) begin
      phase <= ~phase;
      tick  <= tick_en & ~phase;
   end

   // behavioural reference: run lengths in integers
   int rise_t [6] = '{ADP_R, VAB_R, OVP_R, OCP_R, TS_R, SOVP_R};
   int fall_t [6] = '{ADP_F, VAB_F, OVP_F, OCP_F, TS_F, SOVP_F};
   bit m_st [6];
   int m_run [6];
   int m_rel;
   bit m_lat, m_prev;

   always @(posedge clk) begin
      int nrel;
      bit nlat;
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) begin m_st[i] = 0; m_run[i] = 0; end
         m_rel = 0; m_lat = 0; m_prev = 0;
      end else begin
         if (m_st[3]) nrel = RELAX;
         else if (tick && m_rel > 0) nrel = m_rel - 1;
         else nrel = m_rel;
         if (m_prev && !raw[0]) nlat = 0;
         else nlat = m_lat | m_st[5];
         m_prev = raw[0];
         for (int i = 0; i < 6; i++) begin
            if (raw[i] == m_st[i]) m_run[i] = 0;
            else if (tick) begin
               m_run[i]++;
               if (m_run[i] >= (m_st[i] ? fall_t[i] : rise_t[i])) begin
                  m_st[i] = raw[i]; m_run[i] = 0;
               end
            end
         end
         m_rel = nrel; m_lat = nlat;
      end
   end

   function automatic bit model_sw();
      return m_st[0] & m_st[1] & ~m_st[2] & ~(m_st[3] | (m_rel > 0)) & ~m_st[4] & ~m_lat;
   endfunction

   // per-clock comparison against the model (R5 combination, R11 status)
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (sw_en !== model_sw() || adapter_ok !== m_st[0]) begin
            errors++;
            $display("FAIL R5/R11 model: sw_en=%0b adapter_ok=%0b expected %0b %0b at %0t",
                     sw_en, adapter_ok, model_sw(), m_st[0], $time);
         end
      end
   end

   task automatic chk(input string req, input bit exp_sw, input bit exp_ok);
      checks++;
      if (sw_en !== exp_sw || adapter_ok !== exp_ok) begin
         errors++;
         $display("FAIL %s: sw_en=%0b adapter_ok=%0b expected %0b %0b at %0t",
                  req, sw_en, adapter_ok, exp_sw, exp_ok, $time);
      end
   endtask

   task automatic ticks(input int n);
      repeat (2 * n) @(negedge clk);
   endtask

   task automatic setraw(input int idx, input bit v);
      @(negedge clk);
      raw[idx] = v;
   endtask

   int wd = 0;
   bit done = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000 && !done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", 0, 0);

      // adapter qualification and restart on glitch
      setraw(0, 1);
      ticks(10);
      chk("R2 adapter not yet qualified", 0, 0);
      ticks(5);
      setraw(0, 0);
      ticks(1);
      setraw(0, 1);
      ticks(12);
      chk("R3 adapter count restarted", 0, 0);
      ticks(12);
      chk("R2 adapter qualified", 0, 1);

      // supply-above-battery qualification
      setraw(1, 1);
      ticks(20);
      chk("R4 supply not yet qualified", 0, 1);
      ticks(22);
      chk("R4 supply qualified, switch on", 1, 1);

      // input overvoltage
      setraw(2, 1);
      ticks(5);
      chk("R6 ovp before settle", 1, 1);
      ticks(7);
      chk("R6 ovp off, R11 status kept", 0, 1);
      setraw(2, 0);
      ticks(15);
      chk("R6 ovp removal not yet settled", 0, 1);
      ticks(17);
      chk("R6 switch back on", 1, 1);

      // supply loss
      setraw(1, 0);
      ticks(5);
      chk("R4 supply loss before settle", 1, 1);
      ticks(7);
      chk("R4 supply loss, switch off", 0, 1);
      setraw(1, 1);
      ticks(42);
      chk("R4 supply requalified", 1, 1);

      // tick gating
      @(negedge clk);
      tick_en = 1'b0;
      raw[2] = 1'b1;
      repeat (100) @(negedge clk);
      chk("R12 no ticks, ovp has no effect", 1, 1);
      raw[2] = 1'b0;
      @(negedge clk);
      tick_en = 1'b1;
      ticks(2);
      chk("R12 ticks resumed, state unchanged", 1, 1);

      // overcurrent relax
      setraw(3, 1);
      ticks(5);
      chk("R7 overcurrent, switch off", 0, 1);
      setraw(3, 0);
      ticks(150);
      chk("R7 relax still running", 0, 1);
      ticks(160);
      chk("R7 automatic retry", 1, 1);

      // thermal, first a short pulse
      setraw(4, 1);
      ticks(5);
      setraw(4, 0);
      ticks(3);
      chk("R3 short thermal pulse ignored", 1, 1);
      setraw(4, 1);
      ticks(12);
      chk("R8 thermal shutdown", 0, 1);
      setraw(4, 0);
      ticks(50);
      chk("R8 thermal clear not settled", 0, 1);
      ticks(55);
      chk("R8 thermal cleared", 1, 1);

      // system overvoltage latch
      setraw(5, 1);
      ticks(30);
      chk("R9 system ovp latched off", 0, 1);
      setraw(5, 0);
      ticks(20);
      chk("R9 latch holds after removal", 0, 1);
      setraw(0, 0);
      ticks(5);
      chk("R2 adapter fall", 0, 0);
      setraw(0, 1);
      ticks(25);
      chk("R10 latch cleared by adapter fall", 1, 1);

      // reset mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 reset clears state", 0, 0);
      rst_n = 1'b1;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule